// File: doc/BRIEF.md
# Wavefront Register Window Mapper

This block holds the register windows of the wavefront slots on one SIMD unit. Each slot owns two windows, one in the vector register file and one in the scalar register file. A window is a base index and a reserved count. Two combinational query ports turn a slot-relative register index into a physical register file index. The physical index is the window base plus the logical index, wrapped around the end of the file. A query whose index lies outside the slot's window raises an error.

An allocate request grants a window in each file. Each file keeps a next-free pointer: the window starts at the pointer, and the pointer then moves on by the demand, wrapping at the end of the file. Each file also keeps a running total of reserved registers. Going over the file capacity sets a sticky error flag.

A free request takes the slot's counts off the totals. It then walks the slot's window one register per clock, through the same mapping. For each register it issues a busy-clear write on a single write port: all vector registers first, then all scalar registers. A one-cycle done pulse ends the walk, and the slot's bases and counts return to zero. No allocate or free is accepted while a walk runs.

Top module: `wfreg_window_mapper`

## Requirements
- R1: With no error, `vq_phys_o` equals (vector base of `vq_slot_i` + `vq_idx_i`) modulo VREGS. `vq_err_o` is 1 exactly when `vq_idx_i` is not below the slot's reserved vector count, which includes any slot with a count of zero.
- R2: With no error, `sq_phys_o` equals (scalar base of `sq_slot_i` + `sq_idx_i`) modulo SREGS. `sq_err_o` is 0 only when the slot's reserved scalar count is above zero and `sq_idx_i` is below it.
- R3: An accepted allocate sets the slot's vector base to the vector next-free pointer and its vector count to `alloc_vdem_i`. The pointer advances by the demand modulo VREGS, and `vtot_o` grows by the demand. The scalar side does the same with `alloc_sdem_i`, SREGS and `stot_o`. All of these are visible from the cycle after the request.
- R4: An allocate with `alloc_sdem_i` equal to 0 leaves the slot's scalar base and count, the scalar pointer and `stot_o` unchanged.
- R5: `err_o` goes to 1 in the cycle after an allocate that takes `vtot_o` above VREGS or `stot_o` above SREGS. It stays at 1 until a cycle with `err_clr_i` high, and is 0 in the cycle after that.
- R6: An accepted free subtracts the slot's counts from `vtot_o` and `stot_o` in the cycle after the request. A total that would go below zero sets `err_o` and holds at zero instead.
- R7: After an accepted free, the block drives `clr_we_o` for one register per cycle, starting the cycle after the request. It first covers vector logical indices 0 up to count−1 with `clr_file_o`=0, then scalar indices 0 up to count−1 with `clr_file_o`=1. `clr_addr_o` carries the mapped physical index in each case.
- R8: `busy_o` is 1 from the cycle after an accepted free until the end of the walk. `done_o` is high for exactly one cycle, the cycle after the last clear, or the cycle after the request for an empty slot. Allocate and free requests made while `busy_o` is 1 are ignored.
- R9: Once the walk is done, the freed slot's counts and bases are zero, so both of its queries report an error.
- R10: When allocate and free are requested in the same idle cycle, the free is taken and the allocate is dropped.
- R11: After reset, both totals are 0, `err_o`, `busy_o`, `done_o` and `clr_we_o` are 0, and every slot's queries report an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req_i | input | 1 | Allocate request |
| alloc_slot_i | input | SW | Slot to allocate |
| alloc_vdem_i | input | VCW | Vector register demand |
| alloc_sdem_i | input | SCW | Scalar register demand (0 = none) |
| free_req_i | input | 1 | Free request |
| free_slot_i | input | SW | Slot to free |
| vq_slot_i | input | SW | Vector query slot |
| vq_idx_i | input | VCW | Vector query logical index |
| vq_phys_o | output | VPW | Vector physical index |
| vq_err_o | output | 1 | Vector query out of window |
| sq_slot_i | input | SW | Scalar query slot |
| sq_idx_i | input | SCW | Scalar query logical index |
| sq_phys_o | output | SPW | Scalar physical index |
| sq_err_o | output | 1 | Scalar query out of window |
| clr_we_o | output | 1 | Busy-clear write strobe |
| clr_file_o | output | 1 | Busy-clear target: 0 vector, 1 scalar |
| clr_addr_o | output | AW | Busy-clear physical register index |
| busy_o | output | 1 | Free walk in progress |
| done_o | output | 1 | One-cycle pulse at end of walk |
| err_clr_i | input | 1 | Clears the sticky error flag |
| err_o | output | 1 | Sticky overflow/underflow flag |
| vtot_o | output | TVW | Vector registers reserved in total |
| stot_o | output | TSW | Scalar registers reserved in total |

## Verification
A corrupted base, count or pointer shows up on the query ports at once, because the mapping is combinational. It also shows on the clear-address sequence of the next free of that slot. A wrong total appears on `vtot_o`/`stot_o` one cycle after the allocate or free that produced it, and may set `err_o` at the wrong moment. A fault in the walk sequencer shows within the walk itself: as a wrong number of clear strobes, as vector and scalar clears in the wrong order, or as a `done_o` pulse in the wrong cycle. A request that leaks through while busy changes a total one cycle later.

// File: rtl/wfreg_pkg.sv
package wfreg_pkg;
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_VEC  = 2'd1,
      WK_SCL  = 2'd2,
      WK_DONE = 2'd3
   } walk_st_t;
endpackage

// File: rtl/wfreg_map.sv
module wfreg_map #(
   parameter int NREG = 32,
   parameter int PW   = 5,
   parameter int CW   = 6,
   parameter int IW   = 6
) (
   input  logic [PW-1:0] base_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [IW-1:0] idx_i,
   output logic [PW-1:0] phys_o,
   output logic          err_o
);
   localparam int SUMW = ((PW > IW) ? PW : IW) + 1;

   generate
      if ((NREG & (NREG - 1)) == 0) begin : g_pow2
         // power-of-two file: the wrap is a plain truncation
         assign phys_o = base_i + PW'(idx_i);
      end else begin : g_mod
         logic [SUMW-1:0] sum;
         assign sum    = SUMW'(base_i) + SUMW'(idx_i);
         assign phys_o = PW'(sum % SUMW'(NREG));
      end
   endgenerate

   // an empty window rejects every index
   assign err_o = (32'(idx_i) >= 32'(cnt_i));
endmodule

// File: rtl/wfreg_walk.sv
module wfreg_walk
   import wfreg_pkg::*;
#(
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [IW-1:0] vcnt_i,
   input  logic [IW-1:0] scnt_i,
   output walk_st_t      st_o,
   output logic [IW-1:0] idx_o
);
   walk_st_t      st;
   logic [IW-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= WK_IDLE;
         idx <= '0;
      end else begin
         unique case (st)
            WK_IDLE: if (start_i) begin
               idx <= '0;
               if (vcnt_i != '0)      st <= WK_VEC;
               else if (scnt_i != '0) st <= WK_SCL;
               else                   st <= WK_DONE;
            end
            WK_VEC: if (idx == vcnt_i - 1'b1) begin
               idx <= '0;
               st  <= (scnt_i != '0) ? WK_SCL : WK_DONE;
            end else begin
               idx <= idx + 1'b1;
            end
            WK_SCL: if (idx == scnt_i - 1'b1) begin
               idx <= '0;
               st  <= WK_DONE;
            end else begin
               idx <= idx + 1'b1;
            end
            WK_DONE: st <= WK_IDLE;
            default: st <= WK_IDLE;
         endcase
      end
   end

   assign st_o  = st;
   assign idx_o = idx;
endmodule

// File: rtl/wfreg_window_mapper.sv
module wfreg_window_mapper
   import wfreg_pkg::*;
#(
   parameter int SLOTS = 4,
   parameter int VREGS = 32,
   parameter int SREGS = 16,
   localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int VPW = $clog2(VREGS),
   localparam int SPW = $clog2(SREGS),
   localparam int VCW = $clog2(VREGS + 1),
   localparam int SCW = $clog2(SREGS + 1),
   localparam int AW  = (VPW > SPW) ? VPW : SPW,
   localparam int TVW = $clog2(SLOTS * VREGS + 1),
   localparam int TSW = $clog2(SLOTS * SREGS + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           alloc_req_i,
   input  logic [SW-1:0]  alloc_slot_i,
   input  logic [VCW-1:0] alloc_vdem_i,
   input  logic [SCW-1:0] alloc_sdem_i,
   input  logic           free_req_i,
   input  logic [SW-1:0]  free_slot_i,
   input  logic [SW-1:0]  vq_slot_i,
   input  logic [VCW-1:0] vq_idx_i,
   output logic [VPW-1:0] vq_phys_o,
   output logic           vq_err_o,
   input  logic [SW-1:0]  sq_slot_i,
   input  logic [SCW-1:0] sq_idx_i,
   output logic [SPW-1:0] sq_phys_o,
   output logic           sq_err_o,
   output logic           clr_we_o,
   output logic           clr_file_o,
   output logic [AW-1:0]  clr_addr_o,
   output logic           busy_o,
   output logic           done_o,
   input  logic           err_clr_i,
   output logic           err_o,
   output logic [TVW-1:0] vtot_o,
   output logic [TSW-1:0] stot_o
);
   localparam int IW = (VCW > SCW) ? VCW : SCW;

   generate
      if (SLOTS < 1)  begin : g_bad_slots $error("SLOTS must be at least 1"); end
      if (VREGS < 2)  begin : g_bad_vregs $error("VREGS must be at least 2"); end
      if (SREGS < 2)  begin : g_bad_sregs $error("SREGS must be at least 2"); end
   endgenerate

   logic [VPW-1:0] vbase [SLOTS];
   logic [VCW-1:0] vcnt  [SLOTS];
   logic [SPW-1:0] sbase [SLOTS];
   logic [SCW-1:0] scnt  [SLOTS];
   logic [VPW-1:0] vptr;
   logic [SPW-1:0] sptr;
   logic [TVW-1:0] vtot;
   logic [TSW-1:0] stot;
   logic [SW-1:0]  wslot;
   logic           err;

   walk_st_t       wst;
   logic [IW-1:0]  widx;
   logic           idle, take_free, take_alloc, fin;
   logic [SW-1:0]  csel;
   logic [VPW-1:0] wv_phys;
   logic [SPW-1:0] ws_phys;
   logic           wv_err, ws_err;
   logic [TVW-1:0] vtot_nxt;
   logic [TSW-1:0] stot_nxt;
   logic           err_set;

   assign idle       = (wst == WK_IDLE);
   assign take_free  = free_req_i & idle;
   assign take_alloc = alloc_req_i & idle & ~free_req_i;
   assign fin        = (wst == WK_DONE);
   assign csel       = idle ? free_slot_i : wslot;
   assign vtot_nxt   = vtot + TVW'(alloc_vdem_i);
   assign stot_nxt   = stot + TSW'(alloc_sdem_i);

   // query mappers
   wfreg_map #(.NREG(VREGS), .PW(VPW), .CW(VCW), .IW(VCW)) i_vq_map (
      .base_i(vbase[vq_slot_i]), .cnt_i(vcnt[vq_slot_i]), .idx_i(vq_idx_i),
      .phys_o(vq_phys_o), .err_o(vq_err_o));
   wfreg_map #(.NREG(SREGS), .PW(SPW), .CW(SCW), .IW(SCW)) i_sq_map (
      .base_i(sbase[sq_slot_i]), .cnt_i(scnt[sq_slot_i]), .idx_i(sq_idx_i),
      .phys_o(sq_phys_o), .err_o(sq_err_o));

   // walk mappers for the busy-clear sequence
   wfreg_map #(.NREG(VREGS), .PW(VPW), .CW(VCW), .IW(IW)) i_vw_map (
      .base_i(vbase[wslot]), .cnt_i(vcnt[wslot]), .idx_i(widx),
      .phys_o(wv_phys), .err_o(wv_err));
   wfreg_map #(.NREG(SREGS), .PW(SPW), .CW(SCW), .IW(IW)) i_sw_map (
      .base_i(sbase[wslot]), .cnt_i(scnt[wslot]), .idx_i(widx),
      .phys_o(ws_phys), .err_o(ws_err));

   wfreg_walk #(.IW(IW)) i_walk (
      .clk(clk), .rst_n(rst_n), .start_i(take_free),
      .vcnt_i(IW'(vcnt[csel])), .scnt_i(IW'(scnt[csel])),
      .st_o(wst), .idx_o(widx));

   always_comb begin
      err_set = 1'b0;
      if (take_alloc && (vtot_nxt > TVW'(VREGS))) err_set = 1'b1;
      if (take_alloc && (alloc_sdem_i != '0) && (stot_nxt > TSW'(SREGS))) err_set = 1'b1;
      if (take_free && (vtot < TVW'(vcnt[free_slot_i]))) err_set = 1'b1;
      if (take_free && (stot < TSW'(scnt[free_slot_i]))) err_set = 1'b1;
      // a walk index escaping its window is a state fault
      if ((wst == WK_VEC && wv_err) || (wst == WK_SCL && ws_err)) err_set = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) begin
            vbase[i] <= '0;
            vcnt[i]  <= '0;
            sbase[i] <= '0;
            scnt[i]  <= '0;
         end
         vptr  <= '0;
         sptr  <= '0;
         vtot  <= '0;
         stot  <= '0;
         wslot <= '0;
         err   <= 1'b0;
      end else begin
         err <= err_set | (err & ~err_clr_i);
         if (take_alloc) begin
            vbase[alloc_slot_i] <= vptr;
            vcnt[alloc_slot_i]  <= alloc_vdem_i;
            vptr <= VPW'((32'(vptr) + 32'(alloc_vdem_i)) % VREGS);
            vtot <= vtot_nxt;
            if (alloc_sdem_i != '0) begin
               sbase[alloc_slot_i] <= sptr;
               scnt[alloc_slot_i]  <= alloc_sdem_i;
               sptr <= SPW'((32'(sptr) + 32'(alloc_sdem_i)) % SREGS);
               stot <= stot_nxt;
            end
         end
         if (take_free) begin
            wslot <= free_slot_i;
            vtot  <= (vtot < TVW'(vcnt[free_slot_i])) ? '0 : vtot - TVW'(vcnt[free_slot_i]);
            stot  <= (stot < TSW'(scnt[free_slot_i])) ? '0 : stot - TSW'(scnt[free_slot_i]);
         end
         if (fin) begin
            vbase[wslot] <= '0;
            vcnt[wslot]  <= '0;
            sbase[wslot] <= '0;
            scnt[wslot]  <= '0;
         end
      end
   end

   assign clr_we_o   = (wst == WK_VEC) || (wst == WK_SCL);
   assign clr_file_o = (wst == WK_SCL);
   assign clr_addr_o = (wst == WK_VEC) ? AW'(wv_phys) :
                       (wst == WK_SCL) ? AW'(ws_phys) : '0;
   assign busy_o     = ~idle;
   assign done_o     = fin;
   assign err_o      = err;
   assign vtot_o     = vtot;
   assign stot_o     = stot;
endmodule

// File: rtl/wfreg_window_mapper_chk.sv
module wfreg_window_mapper_chk #(
   parameter int SLOTS = 4,
   parameter int VREGS = 32,
   parameter int SREGS = 16,
   localparam int VPW = $clog2(VREGS),
   localparam int SPW = $clog2(SREGS),
   localparam int AW  = (VPW > SPW) ? VPW : SPW,
   localparam int TVW = $clog2(SLOTS * VREGS + 1),
   localparam int TSW = $clog2(SLOTS * SREGS + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           clr_we_o,
   input logic           clr_file_o,
   input logic [AW-1:0]  clr_addr_o,
   input logic           busy_o,
   input logic           done_o,
   input logic           err_clr_i,
   input logic           err_o,
   input logic           vq_err_o,
   input logic [VPW-1:0] vq_phys_o,
   input logic           sq_err_o,
   input logic [SPW-1:0] sq_phys_o,
   input logic [TVW-1:0] vtot_o,
   input logic [TSW-1:0] stot_o
);
   a_r7_clr_only_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_o |-> busy_o);
   a_r7_vec_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_o && !clr_file_o) |-> (32'(clr_addr_o) < VREGS));
   a_r7_scl_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_o && clr_file_o) |-> (32'(clr_addr_o) < SREGS));
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r8_done_after_clears: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && !clr_we_o));
   a_r8_totals_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(vtot_o) && $stable(stot_o)));
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !err_clr_i) |=> err_o);
   a_r1_vphys_range: assert property (@(posedge clk) disable iff (!rst_n)
      !vq_err_o |-> (32'(vq_phys_o) < VREGS));
   a_r2_sphys_range: assert property (@(posedge clk) disable iff (!rst_n)
      !sq_err_o |-> (32'(sq_phys_o) < SREGS));
endmodule

bind wfreg_window_mapper wfreg_window_mapper_chk #(
   .SLOTS(SLOTS), .VREGS(VREGS), .SREGS(SREGS)) i_chk (.*);

// File: tb/test_wfreg_window_mapper.sv
`timescale 1ns/1ps
module test_wfreg_window_mapper;
   localparam int SLOTS = 4, VREGS = 32, SREGS = 16;
   localparam int SW = 2, VPW = 5, SPW = 4, VCW = 6, SCW = 5, AW = 5, TVW = 8, TSW = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_req = 0, free_req = 0, err_clr = 0;
   logic [SW-1:0] alloc_slot = 0, free_slot = 0, vq_slot = 0, sq_slot = 0;
   logic [VCW-1:0] alloc_vdem = 0, vq_idx = 0;
   logic [SCW-1:0] alloc_sdem = 0, sq_idx = 0;
   logic [VPW-1:0] vq_phys;
   logic [SPW-1:0] sq_phys;
   logic vq_err, sq_err, clr_we, clr_file, busy, done, err;
   logic [AW-1:0] clr_addr;
   logic [TVW-1:0] vtot;
   logic [TSW-1:0] stot;

   always #5 clk = ~clk;

   wfreg_window_mapper #(.SLOTS(SLOTS), .VREGS(VREGS), .SREGS(SREGS)) i_wfreg_window_mapper (
      .clk(clk), .rst_n(rst_n),
      .alloc_req_i(alloc_req), .alloc_slot_i(alloc_slot), .alloc_vdem_i(alloc_vdem),
      .alloc_sdem_i(alloc_sdem), .free_req_i(free_req), .free_slot_i(free_slot),
      .vq_slot_i(vq_slot), .vq_idx_i(vq_idx), .vq_phys_o(vq_phys), .vq_err_o(vq_err),
      .sq_slot_i(sq_slot), .sq_idx_i(sq_idx), .sq_phys_o(sq_phys), .sq_err_o(sq_err),
      .clr_we_o(clr_we), .clr_file_o(clr_file), .clr_addr_o(clr_addr),
      .busy_o(busy), .done_o(done), .err_clr_i(err_clr), .err_o(err),
      .vtot_o(vtot), .stot_o(stot));

   int nchk = 0, nfail = 0;
   int mvb[SLOTS], mvc[SLOTS], msb[SLOTS], msc[SLOTS];
   int mvp = 0, msp = 0, mvt = 0, mst = 0;
   bit merr = 0;

   task automatic chk(string rq, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int vmap(int s, int i); return (mvb[s] + i) % VREGS; endfunction
   function automatic int smap(int s, int i); return (msb[s] + i) % SREGS; endfunction

   task automatic q_chk(int s, int vi, int si);
      vq_slot = SW'(s); vq_idx = VCW'(vi);
      sq_slot = SW'(s); sq_idx = SCW'(si);
      #1;
      chk("R1 vq_err", int'(vq_err), int'(vi >= mvc[s]));
      if (vi < mvc[s]) chk("R1 vq_phys", int'(vq_phys), vmap(s, vi));
      chk("R2 sq_err", int'(sq_err), int'(!(msc[s] > 0 && si < msc[s])));
      if (si < msc[s]) chk("R2 sq_phys", int'(sq_phys), smap(s, si));
   endtask

   task automatic tot_chk(string rq);
      chk({rq, " vtot"}, int'(vtot), mvt);
      chk({rq, " stot"}, int'(stot), mst);
      chk({rq, " err"}, int'(err), int'(merr));
   endtask

   task automatic do_alloc(int s, int v, int sd);
      @(negedge clk);
      alloc_req = 1; alloc_slot = SW'(s); alloc_vdem = VCW'(v); alloc_sdem = SCW'(sd);
      @(negedge clk);
      alloc_req = 0;
      mvb[s] = mvp; mvc[s] = v; mvp = (mvp + v) % VREGS; mvt += v;
      if (mvt > VREGS) merr = 1;
      if (sd != 0) begin
         msb[s] = msp; msc[s] = sd; msp = (msp + sd) % SREGS; mst += sd;
         if (mst > SREGS) merr = 1;
      end
      tot_chk("R3");
   endtask

   // mode 0: plain, 1: allocate in the same cycle, 2: allocate held during walk
   task automatic do_free(int s, int mode);
      @(negedge clk);
      free_req = 1; free_slot = SW'(s);
      if (mode != 0) begin
         alloc_req = 1; alloc_slot = SW'((s + 1) % SLOTS); alloc_vdem = 6'd3; alloc_sdem = 5'd1;
      end
      @(negedge clk);
      free_req = 0;
      alloc_req = (mode == 2);
      mvt -= mvc[s]; mst -= msc[s];
      chk("R6 vtot", int'(vtot), mvt);
      chk("R6 stot", int'(stot), mst);
      for (int i = 0; i < mvc[s]; i++) begin
         chk("R7 vec clr_we", int'(clr_we), 1);
         chk("R7 vec clr_file", int'(clr_file), 0);
         chk("R7 vec clr_addr", int'(clr_addr), vmap(s, i));
         chk("R8 busy", int'(busy), 1);
         @(negedge clk);
      end
      for (int i = 0; i < msc[s]; i++) begin
         chk("R7 scl clr_we", int'(clr_we), 1);
         chk("R7 scl clr_file", int'(clr_file), 1);
         chk("R7 scl clr_addr", int'(clr_addr), smap(s, i));
         @(negedge clk);
      end
      chk("R8 done", int'(done), 1);
      chk("R7 no clear at done", int'(clr_we), 0);
      @(negedge clk);
      alloc_req = 0;
      chk("R8 done low", int'(done), 0);
      chk("R8 busy low", int'(busy), 0);
      mvb[s] = 0; mvc[s] = 0; msb[s] = 0; msc[s] = 0;
      tot_chk(mode == 1 ? "R10" : "R8");
   endtask

   task automatic clear_err();
      @(negedge clk); err_clr = 1;
      @(negedge clk); err_clr = 0;
      merr = 0;
      chk("R5 err cleared", int'(err), 0);
   endtask

   initial begin
      for (int i = 0; i < SLOTS; i++) begin mvb[i] = 0; mvc[i] = 0; msb[i] = 0; msc[i] = 0; end
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11 vtot", int'(vtot), 0);
      chk("R11 stot", int'(stot), 0);
      chk("R11 err", int'(err), 0);
      chk("R11 busy", int'(busy), 0);
      chk("R11 clr_we", int'(clr_we), 0);
      for (int s = 0; s < SLOTS; s++) begin
         vq_slot = SW'(s); sq_slot = SW'(s); vq_idx = 0; sq_idx = 0; #1;
         chk("R11 vq_err", int'(vq_err), 1);
         chk("R11 sq_err", int'(sq_err), 1);
      end

      // directed windows
      do_alloc(0, 5, 3);
      q_chk(0, 4, 2); q_chk(0, 5, 3);
      do_alloc(1, 4, 0);                 // R4 zero scalar demand
      chk("R4 stot kept", int'(stot), 3);
      q_chk(1, 3, 0);
      do_alloc(2, 0, 2);
      q_chk(2, 0, 1);
      chk("R2 scalar base literal", int'(sq_phys), 4);
      do_free(0, 2);                     // R8 allocate ignored during walk
      q_chk(0, 0, 0);                    // R9 freed slot errors
      // R5 overflow, R1 wrap
      do_alloc(3, 30, 0);
      chk("R5 err set", int'(err), 1);
      @(negedge clk);
      chk("R5 err held", int'(err), 1);
      q_chk(3, 25, 0);
      chk("R1 wrap literal", int'(vq_phys), 2);
      clear_err();
      do_free(3, 0);
      do_free(1, 1);                     // R10 free wins
      q_chk(2, 0, 0);
      do_free(2, 0);
      do_free(0, 0);                     // empty slot walk

      // random phase
      for (int n = 0; n < 400; n++) begin
         int s;
         s = int'($urandom % SLOTS);
         if (mvc[s] == 0 && msc[s] == 0)
            do_alloc(s, int'($urandom % 17), int'($urandom % 9));
         else
            do_free(s, int'($urandom % 3));
         if (($urandom % 8) == 0) clear_err();
         for (int k = 0; k < SLOTS; k++)
            q_chk(k, int'($urandom % 20), int'($urandom % 12));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule